// File: doc/BRIEF.md
# Trigger-Started Arithmetic Function Unit

This block is an integer arithmetic unit for a processor whose program consists only of data moves. Software first moves a value into the operand port. A second move into the trigger port starts an operation. The operation is picked by an opcode that is sampled in that same cycle, and it uses the stored operand together with the trigger data. Three operations exist: add, subtract, and a paired operation that produces both the difference and the sum. Each has a fixed latency that software can see. Results land on two registered result ports, and later moves read them from there.

The hardware has no stall and no hazard detection. A result port keeps showing the last result written to it until a newer one replaces it. The compiler's schedule alone decides when a read returns the intended value. The unit is fully pipelined, so it accepts a trigger in every cycle while earlier operations are still in flight. When several results reach the same port at the same clock edge, the most recently triggered one wins.

Top module: `trig_arith_unit`

## Requirements
- R1: While reset is asserted, and afterwards until the first completion, both result ports read zero.
- R2: A write to the operand port alone (opWrEn high, trigWrEn low) only stores opData. No result port changes.
- R3: Opcode 0 (add) sets res0 to stored operand plus trigData, modulo 2^DATA_W. The value is readable in the cycle after the trigger cycle, and res1 is left unchanged.
- R4: Opcode 1 (subtract) sets res0 to stored operand minus trigData, modulo 2^DATA_W. The value is readable in the third cycle after the trigger. In the first and second cycles, res0 still shows the previous result.
- R5: Opcode 2 (paired) sets res0 to stored operand minus trigData and res1 to stored operand plus trigData. Both are readable in the second cycle after the trigger and not in the first.
- R6: Opcode 3 is reserved. A trigger carrying it changes no result port.
- R7: A trigger is accepted in every cycle. Back-to-back triggers with different opcodes all deliver their results at their own latencies.
- R8: A trigger uses the operand stored before its cycle. An operand write in the same cycle, or in any later cycle, affects only later triggers, including operations already in flight.
- R9: When results from triggers in different cycles reach a result port at the same edge, the port takes the result of the most recent trigger.
- R10: A result port holds its value until a later completion overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opWrEn | input | 1 | Operand port write strobe |
| opData | input | DATA_W | Operand port write data |
| trigWrEn | input | 1 | Trigger port write strobe; starts an operation |
| trigData | input | DATA_W | Trigger port write data (second operand) |
| opcode | input | 2 | 0 add, 1 subtract, 2 paired, 3 reserved; sampled with the trigger |
| res0 | output | DATA_W | First result port: sum of add, difference of subtract and paired |
| res1 | output | DATA_W | Second result port: sum of paired |

## Verification
A table of isolated operand-then-trigger pairs runs every opcode, including carries out of the top bit and borrows below zero. These cases separate correct wrapping arithmetic and port routing from swapped outputs or a reserved opcode that leaks through. Directed sequences then sample each port in every cycle after a subtract or paired trigger, which separates correct latency from a result that is early or late. Two back-to-back triggers in the orders subtract, paired, add and add, paired, subtract show, respectively, that the latest trigger wins a collision and that in-flight work is never dropped. Writing the operand in the trigger cycle, or just after a subtract trigger, tells whether the stored operand is sampled at the right moment.

// File: rtl/trig_arith_pkg.sv
package trig_arith_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_PAIR = 2'd2,
    OP_NONE = 2'd3
  } fuOp_e;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_ADD  = 2'd1,
    SRC_PAIR = 2'd2,
    SRC_SUB  = 2'd3
  } res0Src_e;

  typedef struct packed {
    logic     loadOpnd;
    res0Src_e res0Src;
    logic     res1Load;
  } fuStrobe_t;

endpackage

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [DEPTH-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/trig_arith_ctrl.sv
module trig_arith_ctrl
  import trig_arith_pkg::*;
#(
  parameter int PAIR_LAT = 2,
  parameter int SUB_LAT  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opWrEn,
  input  logic       trigWrEn,
  input  logic [1:0] opcode,
  output fuStrobe_t  strobe
);

  localparam int PAIR_D    = PAIR_LAT - 1;
  localparam int SUB_D     = SUB_LAT - 1;
  // shorter latency completing means a younger trigger
  localparam bit PAIR_WINS = PAIR_LAT < SUB_LAT;

  logic startAdd;
  logic startPair;
  logic startSub;
  logic pairDone;
  logic subDone;

  always_comb begin
    startAdd  = trigWrEn && (opcode == OP_ADD);
    startPair = trigWrEn && (opcode == OP_PAIR);
    startSub  = trigWrEn && (opcode == OP_SUB);
  end

  trig_delay_line #(.WIDTH(1), .DEPTH(PAIR_D)) u_pairVld (
    .clk  (clk),
    .rstN (rstN),
    .din  (startPair),
    .dout (pairDone)
  );

  trig_delay_line #(.WIDTH(1), .DEPTH(SUB_D)) u_subVld (
    .clk  (clk),
    .rstN (rstN),
    .din  (startSub),
    .dout (subDone)
  );

  always_comb begin
    strobe.loadOpnd = opWrEn;
    strobe.res1Load = pairDone;
    if (startAdd) begin
      strobe.res0Src = SRC_ADD;
    end else if (PAIR_WINS && pairDone) begin
      strobe.res0Src = SRC_PAIR;
    end else if (subDone) begin
      strobe.res0Src = SRC_SUB;
    end else if (pairDone) begin
      strobe.res0Src = SRC_PAIR;
    end else begin
      strobe.res0Src = SRC_KEEP;
    end
  end

endmodule

// File: rtl/trig_arith_dpath.sv
module trig_arith_dpath
  import trig_arith_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PAIR_LAT = 2,
  parameter int SUB_LAT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fuStrobe_t         strobe,
  input  logic [DATA_W-1:0] opData,
  input  logic [DATA_W-1:0] trigData,
  output logic [DATA_W-1:0] res0,
  output logic [DATA_W-1:0] res1
);

  localparam int PAIR_D = PAIR_LAT - 1;
  localparam int SUB_D  = SUB_LAT - 1;
  localparam int PAIR_W = 2 * DATA_W;

  logic [DATA_W-1:0] opnd1;
  logic [DATA_W-1:0] sumNow;
  logic [DATA_W-1:0] diffNow;
  logic [PAIR_W-1:0] pairOut;
  logic [DATA_W-1:0] subOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opnd1 <= '0;
    end else if (strobe.loadOpnd) begin
      opnd1 <= opData;
    end
  end

  always_comb begin
    sumNow  = opnd1 + trigData;
    diffNow = opnd1 - trigData;
  end

  trig_delay_line #(.WIDTH(PAIR_W), .DEPTH(PAIR_D)) u_pairData (
    .clk  (clk),
    .rstN (rstN),
    .din  ({diffNow, sumNow}),
    .dout (pairOut)
  );

  trig_delay_line #(.WIDTH(DATA_W), .DEPTH(SUB_D)) u_subData (
    .clk  (clk),
    .rstN (rstN),
    .din  (diffNow),
    .dout (subOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      res0 <= '0;
    end else begin
      case (strobe.res0Src)
        SRC_ADD:  res0 <= sumNow;
        SRC_PAIR: res0 <= pairOut[PAIR_W-1:DATA_W];
        SRC_SUB:  res0 <= subOut;
        default:  res0 <= res0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      res1 <= '0;
    end else if (strobe.res1Load) begin
      res1 <= pairOut[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/trig_arith_unit.sv
module trig_arith_unit
  import trig_arith_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PAIR_LAT = 2,
  parameter int SUB_LAT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opWrEn,
  input  logic [DATA_W-1:0] opData,
  input  logic              trigWrEn,
  input  logic [DATA_W-1:0] trigData,
  input  logic [1:0]        opcode,
  output logic [DATA_W-1:0] res0,
  output logic [DATA_W-1:0] res1
);

  fuStrobe_t strobe;

  trig_arith_ctrl #(.PAIR_LAT(PAIR_LAT), .SUB_LAT(SUB_LAT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opWrEn   (opWrEn),
    .trigWrEn (trigWrEn),
    .opcode   (opcode),
    .strobe   (strobe)
  );

  trig_arith_dpath #(.DATA_W(DATA_W), .PAIR_LAT(PAIR_LAT), .SUB_LAT(SUB_LAT)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opData   (opData),
    .trigData (trigData),
    .res0     (res0),
    .res1     (res1)
  );

endmodule

// File: rtl/trig_arith_chk.sv
module trig_arith_chk #(
  parameter int DATA_W   = 8,
  parameter int PAIR_LAT = 2,
  parameter int SUB_LAT  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              opWrEn,
  input logic [DATA_W-1:0] opData,
  input logic              trigWrEn,
  input logic [DATA_W-1:0] trigData,
  input logic [1:0]        opcode,
  input logic [DATA_W-1:0] res0,
  input logic [DATA_W-1:0] res1
);

  localparam int MAX_LAT = (PAIR_LAT > SUB_LAT) ? PAIR_LAT : SUB_LAT;
  localparam int CW      = $clog2(MAX_LAT + 1) + 1;
  localparam int HIST_W  = PAIR_LAT - 1;

  logic [DATA_W-1:0] shadowA;
  logic [DATA_W-1:0] addPred;
  logic [CW-1:0]     quiet;
  logic [HIST_W-1:0] pairHist;
  logic              realTrig;
  logic              pairTrig;

  assign addPred  = shadowA + trigData;
  assign realTrig = trigWrEn && (opcode != 2'd3);
  assign pairTrig = trigWrEn && (opcode == 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowA  <= '0;
      quiet    <= '0;
      pairHist <= '0;
    end else begin
      if (opWrEn) shadowA <= opData;
      if (realTrig) quiet <= '0;
      else if (quiet < CW'(MAX_LAT)) quiet <= quiet + 1'b1;
      if (HIST_W > 1) pairHist <= {pairHist[HIST_W-2:0], pairTrig};
      else            pairHist <= HIST_W'(pairTrig);
    end
  end

  // R1: results are zero across reset
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rstN |=> (res0 == '0) && (res1 == '0));

  // R3, R8: add result from the operand stored before the trigger
  assert_add_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trigWrEn && opcode == 2'd0) |=> res0 == $past(addPred));

  // R10, R6, R2: with nothing in flight and no real trigger, ports hold
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (quiet >= CW'(MAX_LAT) && !realTrig) |=>
      (realTrig || ($stable(res0) && $stable(res1))));

  // R5: res1 moves only at a paired completion edge
  assert_res1_pair_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(res1) |-> $past(pairHist[HIST_W-1]));

endmodule

bind trig_arith_unit trig_arith_chk #(
  .DATA_W(DATA_W), .PAIR_LAT(PAIR_LAT), .SUB_LAT(SUB_LAT)
) u_chk (
  .clk(clk), .rstN(rstN), .opWrEn(opWrEn), .opData(opData),
  .trigWrEn(trigWrEn), .trigData(trigData), .opcode(opcode),
  .res0(res0), .res1(res1)
);

// File: tb/trig_arith_unit_tb.sv
module trig_arith_unit_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opWrEn = 1'b0;
  logic [W-1:0] opData = '0;
  logic         trigWrEn = 1'b0;
  logic [W-1:0] trigData = '0;
  logic [1:0]   opcode = 2'd0;
  logic [W-1:0] res0;
  logic [W-1:0] res1;

  int nChecks = 0;
  int nFails  = 0;

  logic [W-1:0] exp0 = '0;
  logic [W-1:0] exp1 = '0;
  logic [W-1:0] curA = '0;

  // {operand, trigger data, opcode}
  localparam logic [17:0] VECS [8] = '{
    {8'h12, 8'h34, 2'd0},
    {8'hF0, 8'h20, 2'd0},
    {8'h50, 8'h30, 2'd1},
    {8'h10, 8'h20, 2'd1},
    {8'h7F, 8'h01, 2'd2},
    {8'h00, 8'hFF, 2'd2},
    {8'hAA, 8'h55, 2'd3},
    {8'hFF, 8'hFF, 2'd0}
  };

  trig_arith_unit #(.DATA_W(W), .PAIR_LAT(2), .SUB_LAT(3)) u_dut (
    .clk(clk), .rstN(rstN), .opWrEn(opWrEn), .opData(opData),
    .trigWrEn(trigWrEn), .trigData(trigData), .opcode(opcode),
    .res0(res0), .res1(res1)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, return at the next falling edge
  task automatic step(input logic ow, input logic [W-1:0] a,
                      input logic tw, input logic [W-1:0] b, input logic [1:0] op);
    opWrEn = ow; opData = a; trigWrEn = tw; trigData = b; opcode = op;
    if (ow) curA = a;
    @(negedge clk);
    opWrEn = 1'b0; trigWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] oldA;
    // R1: reset state
    idle(3);
    check("R1 res0 in reset", res0, 8'h00);
    check("R1 res1 in reset", res1, 8'h00);
    rstN = 1'b1;
    idle(2);
    check("R1 res0 after reset", res0, 8'h00);
    check("R1 res1 after reset", res1, 8'h00);

    // R2: operand write alone
    step(1'b1, 8'h77, 1'b0, 8'h00, 2'd0);
    idle(3);
    check("R2 res0 after operand write", res0, exp0);
    check("R2 res1 after operand write", res1, exp1);

    // table walk: R3 R4 R5 R6 isolated operations
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] a, b;
      logic [1:0] op;
      a = VECS[i][17:10]; b = VECS[i][9:2]; op = VECS[i][1:0];
      step(1'b1, a, 1'b0, 8'h00, 2'd0);
      step(1'b0, 8'h00, 1'b1, b, op);
      idle(3);
      case (op)
        2'd0: exp0 = a + b;
        2'd1: exp0 = a - b;
        2'd2: begin exp0 = a - b; exp1 = a + b; end
        default: ;
      endcase
      check($sformatf("R3 R4 R5 R6 vec%0d res0", i), res0, exp0);
      check($sformatf("R3 R4 R5 R6 vec%0d res1", i), res1, exp1);
    end

    // R4: subtract latency, stale reads before ready
    step(1'b1, 8'h40, 1'b0, 8'h00, 2'd0);
    step(1'b0, 8'h00, 1'b1, 8'h05, 2'd1);
    check("R4 res0 cycle1 stale", res0, exp0);
    idle(1);
    check("R4 res0 cycle2 stale", res0, exp0);
    idle(1);
    exp0 = 8'h3B;
    check("R4 res0 cycle3 ready", res0, exp0);

    // R5: paired latency
    step(1'b0, 8'h00, 1'b1, 8'h10, 2'd2);
    check("R5 res0 cycle1 stale", res0, exp0);
    check("R5 res1 cycle1 stale", res1, exp1);
    idle(1);
    exp0 = 8'h30; exp1 = 8'h50;
    check("R5 res0 cycle2 diff", res0, exp0);
    check("R5 res1 cycle2 sum", res1, exp1);

    // R9: subtract, paired, add back to back all land at one edge
    step(1'b0, 8'h00, 1'b1, 8'h01, 2'd1);
    step(1'b0, 8'h00, 1'b1, 8'h02, 2'd2);
    check("R9 res1 before collision", res1, exp1);
    step(1'b0, 8'h00, 1'b1, 8'h03, 2'd0);
    exp0 = 8'h43; exp1 = 8'h42;
    check("R9 res0 latest trigger wins", res0, exp0);
    check("R9 res1 paired sum", res1, exp1);
    idle(3);
    check("R10 res0 held", res0, exp0);
    check("R10 res1 held", res1, exp1);

    // R7: add, paired, subtract back to back
    step(1'b1, 8'h20, 1'b0, 8'h00, 2'd0);
    step(1'b0, 8'h00, 1'b1, 8'h01, 2'd0);
    check("R7 add after edge k", res0, 8'h21);
    step(1'b0, 8'h00, 1'b1, 8'h02, 2'd2);
    check("R7 res0 k+1", res0, 8'h21);
    check("R7 res1 k+1", res1, exp1);
    step(1'b0, 8'h00, 1'b1, 8'h03, 2'd1);
    check("R7 paired diff k+2", res0, 8'h1E);
    check("R7 paired sum k+2", res1, 8'h22);
    idle(1);
    check("R7 res0 k+3", res0, 8'h1E);
    idle(1);
    exp0 = 8'h1D; exp1 = 8'h22;
    check("R7 subtract k+4", res0, exp0);
    check("R7 res1 k+4", res1, exp1);

    // R8: operand write in the trigger cycle uses the old value
    oldA = curA;
    step(1'b1, 8'h90, 1'b1, 8'h01, 2'd0);
    check("R8 same-cycle write uses old operand", res0, oldA + 8'h01);
    step(1'b0, 8'h00, 1'b1, 8'h01, 2'd0);
    check("R8 next trigger uses new operand", res0, 8'h91);
    step(1'b1, 8'h91, 1'b0, 8'h00, 2'd0);
    step(1'b0, 8'h00, 1'b1, 8'h11, 2'd1);
    step(1'b1, 8'h05, 1'b0, 8'h00, 2'd0);
    idle(1);
    exp0 = 8'h80;
    check("R8 in-flight subtract keeps operand", res0, exp0);

    // R6: reserved opcode right after activity
    step(1'b0, 8'h00, 1'b1, 8'h01, 2'd3);
    idle(3);
    check("R6 reserved res0", res0, exp0);
    check("R6 reserved res1", res1, exp1);

    summary();
    $finish;
  end

endmodule